// File: doc/BRIEF.md
# Microcontroller Memory Map Decoder

This block sits between an 8-bit microcontroller core and its memories. The core has separate code and data spaces. The block decodes a code-fetch address and a data-access address independently, and each side has its own strobe. It raises one target select per access. The targets are a 256 KB banked external program ROM, a 256-byte general RAM, a 256-byte scratch memory, the page of on-chip memory-mapped registers, and external data RAM.

Two control registers live in the register page. The first is a 3-bit bank register. It chooses which 32 KB window of the ROM is seen both by code fetches and by the upper half of data space. The second is a configuration register that holds a remap bit. When the remap bit is set and the internal-boot input is high, the scratch memory leaves data space. It then answers code fetches at the bottom of code space as read-only memory.

The decoding is purely combinational. The only state is the two control registers, so the design contains no sequencer. Each access resolves in the cycle it is presented. A register write takes effect from the following cycle.

Top module: `memmap_decoder`

## Requirements
- R1: For every code fetch routed to ROM, `code_rom_addr` = {bank, code_addr[14:0]}. Code addresses 8000h–FFFFh therefore alias onto 0000h–7FFFh.
- R2: The bank register sits at data address 7FF0h and is held in bits 2:0. It resets to 0, and reads return zeros in bits 7:3. A write changes decoding from the next clock cycle.
- R3: When `boot_int_en` is 0, every code fetch selects ROM (`code_sel_rom`=1, `code_sel_scr`=0), including fetches at 0000h–00FFh.
- R4: When `boot_int_en` is 1 and the remap bit is 1, code fetches whose bits 14:8 are zero select the scratch memory. This covers 0000h–00FFh and its alias 8000h–80FFh. All other code fetches select ROM.
- R5: Data addresses 8000h–FFFFh select ROM with `data_rom_addr` = {bank, data_addr[14:0]}. Writes there leave `data_wr_en` at 0.
- R6: Data addresses 7E00h–7EFFh select the general RAM, and writes there are allowed.
- R7: The configuration register sits at data address 7FF4h. Its bit 3 is the remap bit, which resets to 0. Its other bits read as zero.
- R8: Data addresses 7D00h–7DFFh depend on the remap bit. With the remap bit at 0 they select the scratch memory as read/write. With the remap bit at 1 they select external RAM instead, `data_sel_scr` stays 0, and `data_wr_en` stays 0.
- R9: Data addresses below 7D00h select external RAM. Data addresses 7F00h–7FFFh select the register page.
- R10: During a data request exactly one data select is high; with no request all data selects are low. During a code request exactly one code select is high.
- R11: `data_rdata` carries the value of the bank or configuration register during a read request at its address, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| boot_int_en | input | 1 | 1 permits the internal scratch boot region; 0 forces all code to ROM |
| code_req | input | 1 | Code fetch strobe |
| code_addr | input | 16 | Code fetch address |
| code_sel_rom | output | 1 | Code fetch targets external ROM |
| code_sel_scr | output | 1 | Code fetch targets scratch memory |
| code_rom_addr | output | 18 | Banked ROM address for code fetch |
| data_req | input | 1 | Data access strobe |
| data_we | input | 1 | Data access is a write |
| data_addr | input | 16 | Data access address |
| data_wdata | input | 8 | Data write value |
| data_sel_rom | output | 1 | Data access targets ROM window |
| data_sel_gram | output | 1 | Data access targets general RAM |
| data_sel_scr | output | 1 | Data access targets scratch memory |
| data_sel_reg | output | 1 | Data access targets register page |
| data_sel_xram | output | 1 | Data access targets external RAM |
| data_wr_en | output | 1 | Write strobe to the selected target |
| data_rom_addr | output | 18 | Banked ROM address for data access |
| data_rdata | output | 8 | Read value of the bank/configuration registers |

## Verification
The assertions assume that `data_req`, `data_we`, `data_addr` and `data_wdata` stay stable around each rising clock edge. They also assume that `boot_int_en` changes only between accesses. The bench drives all inputs on the falling edge and samples outputs shortly after it, so every input is settled well before the edge the registers and properties use. Register writes are single-cycle requests that are dropped on the next falling edge, so each write is captured exactly once.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int WIN_AW = 15;

    localparam logic [7:0] PG_SCR  = 8'h7D;
    localparam logic [7:0] PG_GRAM = 8'h7E;
    localparam logic [7:0] PG_REG  = 8'h7F;

    localparam int N_TGT = 5;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_PROG = 3'd1,
        TGT_GRAM = 3'd2,
        TGT_SCR  = 3'd3,
        TGT_REG  = 3'd4,
        TGT_XRAM = 3'd5
    } dtgt_e;

endpackage

// File: rtl/memmap_ctrl_regs.sv
module memmap_ctrl_regs
    import memmap_pkg::*;
#(
    parameter int             BANK_W    = 3,
    parameter logic [BANK_W-1:0] BANK_RST = '0,
    parameter logic [15:0]    BANK_ADDR = 16'h7FF0,
    parameter logic [15:0]    CFG_ADDR  = 16'h7FF4,
    parameter int             REMAP_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_req,
    input  logic              data_we,
    input  logic [15:0]       data_addr,
    input  logic [7:0]        data_wdata,
    output logic [BANK_W-1:0] bank_q,
    output logic              remap_q,
    output logic [7:0]        rd_val
);

    logic bank_hit;
    logic cfg_hit;

    assign bank_hit = data_req && (data_addr == BANK_ADDR);
    assign cfg_hit  = data_req && (data_addr == CFG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q  <= BANK_RST;
            remap_q <= 1'b0;
        end else begin
            if (bank_hit && data_we) begin
                bank_q <= data_wdata[BANK_W-1:0];
            end
            if (cfg_hit && data_we) begin
                remap_q <= data_wdata[REMAP_BIT];
            end
        end
    end

    always_comb begin
        rd_val = 8'h00;
        if (bank_hit && !data_we) begin
            rd_val[BANK_W-1:0] = bank_q;
        end else if (cfg_hit && !data_we) begin
            rd_val[REMAP_BIT] = remap_q;
        end
    end

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && data_we && data_addr == BANK_ADDR)
            |=> (bank_q == $past(data_wdata[BANK_W-1:0]))); // R2

    AST_REMAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && data_we && data_addr == CFG_ADDR)
            |=> (remap_q == $past(data_wdata[REMAP_BIT]))); // R7

    AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_req && data_we && data_addr == CFG_ADDR) |=> $stable(remap_q)); // R7

endmodule

// File: rtl/memmap_code_dec.sv
module memmap_code_dec
    import memmap_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int ROM_AW = BANK_W + WIN_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_req,
    input  logic [15:0]       code_addr,
    input  logic              boot_int_en,
    input  logic              remap_q,
    input  logic [BANK_W-1:0] bank_q,
    output logic              sel_rom,
    output logic              sel_scr,
    output logic [ROM_AW-1:0] rom_addr
);

    logic scr_hit;
    logic alias_unused;

    assign alias_unused = code_addr[15];

    assign scr_hit  = boot_int_en && remap_q && (code_addr[14:8] == 7'd0);
    assign sel_scr  = code_req && scr_hit;
    assign sel_rom  = code_req && !scr_hit;
    assign rom_addr = {bank_q, code_addr[WIN_AW-1:0]};

    AST_CODE_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        code_req |-> (sel_rom ^ sel_scr)); // R10

    AST_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_int_en |-> !sel_scr); // R3

    AST_SCR_NEEDS_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        !remap_q |-> !sel_scr); // R4

endmodule

// File: rtl/memmap_data_dec.sv
module memmap_data_dec
    import memmap_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int ROM_AW = BANK_W + WIN_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_req,
    input  logic              data_we,
    input  logic [15:0]       data_addr,
    input  logic              remap_q,
    input  logic [BANK_W-1:0] bank_q,
    output logic [N_TGT-1:0]  sel_vec,
    output logic              wr_en,
    output logic [ROM_AW-1:0] rom_addr
);

    dtgt_e tgt;
    logic  scr_ro_hit;

    always_comb begin
        tgt = TGT_NONE;
        if (data_req) begin
            if (data_addr[15]) begin
                tgt = TGT_PROG;
            end else begin
                unique case (data_addr[15:8])
                    PG_SCR:  tgt = remap_q ? TGT_XRAM : TGT_SCR;
                    PG_GRAM: tgt = TGT_GRAM;
                    PG_REG:  tgt = TGT_REG;
                    default: tgt = TGT_XRAM;
                endcase
            end
        end
    end

    for (genvar i = 0; i < N_TGT; i++) begin : g_sel
        assign sel_vec[i] = (tgt == dtgt_e'(i + 1));
    end

    assign scr_ro_hit = remap_q && (data_addr[15:8] == PG_SCR);
    assign wr_en      = data_req && data_we && (tgt != TGT_PROG) && !scr_ro_hit;
    assign rom_addr   = {bank_q, data_addr[WIN_AW-1:0]};

    AST_DATA_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> ($countones(sel_vec) == 1)); // R10

    AST_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !data_req |-> (sel_vec == '0)); // R10

    AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vec[TGT_PROG - 1] |-> !wr_en); // R5

    AST_SCR_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        remap_q |-> !sel_vec[TGT_SCR - 1]); // R8

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int                BANK_W    = 3,
    parameter logic [BANK_W-1:0] BANK_RST  = '0,
    parameter logic [15:0]       BANK_ADDR = 16'h7FF0,
    parameter logic [15:0]       CFG_ADDR  = 16'h7FF4,
    parameter int                REMAP_BIT = 3,
    localparam int               ROM_AW    = BANK_W + WIN_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_int_en,
    input  logic              code_req,
    input  logic [15:0]       code_addr,
    output logic              code_sel_rom,
    output logic              code_sel_scr,
    output logic [ROM_AW-1:0] code_rom_addr,
    input  logic              data_req,
    input  logic              data_we,
    input  logic [15:0]       data_addr,
    input  logic [7:0]        data_wdata,
    output logic              data_sel_rom,
    output logic              data_sel_gram,
    output logic              data_sel_scr,
    output logic              data_sel_reg,
    output logic              data_sel_xram,
    output logic              data_wr_en,
    output logic [ROM_AW-1:0] data_rom_addr,
    output logic [7:0]        data_rdata
);

    logic [BANK_W-1:0] bank_q;
    logic              remap_q;
    logic [N_TGT-1:0]  dsel;

    memmap_ctrl_regs #(
        .BANK_W    (BANK_W),
        .BANK_RST  (BANK_RST),
        .BANK_ADDR (BANK_ADDR),
        .CFG_ADDR  (CFG_ADDR),
        .REMAP_BIT (REMAP_BIT)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_req   (data_req),
        .data_we    (data_we),
        .data_addr  (data_addr),
        .data_wdata (data_wdata),
        .bank_q     (bank_q),
        .remap_q    (remap_q),
        .rd_val     (data_rdata)
    );

    memmap_code_dec #(.BANK_W(BANK_W)) code_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_req    (code_req),
        .code_addr   (code_addr),
        .boot_int_en (boot_int_en),
        .remap_q     (remap_q),
        .bank_q      (bank_q),
        .sel_rom     (code_sel_rom),
        .sel_scr     (code_sel_scr),
        .rom_addr    (code_rom_addr)
    );

    memmap_data_dec #(.BANK_W(BANK_W)) data_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_req  (data_req),
        .data_we   (data_we),
        .data_addr (data_addr),
        .remap_q   (remap_q),
        .bank_q    (bank_q),
        .sel_vec   (dsel),
        .wr_en     (data_wr_en),
        .rom_addr  (data_rom_addr)
    );

    assign data_sel_rom  = dsel[TGT_PROG - 1];
    assign data_sel_gram = dsel[TGT_GRAM - 1];
    assign data_sel_scr  = dsel[TGT_SCR - 1];
    assign data_sel_reg  = dsel[TGT_REG - 1];
    assign data_sel_xram = dsel[TGT_XRAM - 1];

    AST_CODE_ROM_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        code_sel_rom |-> (code_rom_addr[ROM_AW-1:WIN_AW] == data_rom_addr[ROM_AW-1:WIN_AW])); // R1

endmodule

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_int_en = 1'b1;
    logic        code_req = 1'b0;
    logic [15:0] code_addr = '0;
    logic        code_sel_rom, code_sel_scr;
    logic [17:0] code_rom_addr;
    logic        data_req = 1'b0, data_we = 1'b0;
    logic [15:0] data_addr = '0;
    logic [7:0]  data_wdata = '0;
    logic        data_sel_rom, data_sel_gram, data_sel_scr, data_sel_reg, data_sel_xram;
    logic        data_wr_en;
    logic [17:0] data_rom_addr;
    logic [7:0]  data_rdata;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    memmap_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .boot_int_en(boot_int_en),
        .code_req(code_req), .code_addr(code_addr),
        .code_sel_rom(code_sel_rom), .code_sel_scr(code_sel_scr),
        .code_rom_addr(code_rom_addr),
        .data_req(data_req), .data_we(data_we), .data_addr(data_addr),
        .data_wdata(data_wdata),
        .data_sel_rom(data_sel_rom), .data_sel_gram(data_sel_gram),
        .data_sel_scr(data_sel_scr), .data_sel_reg(data_sel_reg),
        .data_sel_xram(data_sel_xram), .data_wr_en(data_wr_en),
        .data_rom_addr(data_rom_addr), .data_rdata(data_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [4:0] dsel();
        return {data_sel_rom, data_sel_gram, data_sel_scr, data_sel_reg, data_sel_xram};
    endfunction

    task automatic dwrite(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        data_req = 1'b1; data_we = 1'b1; data_addr = a; data_wdata = v;
        @(negedge clk);
        data_req = 1'b0; data_we = 1'b0;
    endtask

    task automatic dprobe(input logic [15:0] a, input logic we);
        @(negedge clk);
        data_req = 1'b1; data_we = we; data_addr = a; data_wdata = 8'h5A;
        #1;
    endtask

    task automatic dstop();
        data_req = 1'b0; data_we = 1'b0;
    endtask

    task automatic cprobe(input logic [15:0] a);
        @(negedge clk);
        code_req = 1'b1; code_addr = a;
        #1;
    endtask

    task automatic t_reset();
        dprobe(16'h7FF0, 1'b0);
        chk("R2 bank reset", data_rdata, 8'h00);
        dprobe(16'h7FF4, 1'b0);
        chk("R7 cfg reset", data_rdata, 8'h00);
        dstop(); #1;
        chk("R10 idle selects", dsel(), 5'b0);
        cprobe(16'h0010);
        chk("R4 no remap -> rom", {code_sel_rom, code_sel_scr}, 2'b10);
        chk("R1 code addr bank0", code_rom_addr, 18'h00010);
    endtask

    task automatic t_code_alias();
        cprobe(16'h8123);
        chk("R1 alias", code_rom_addr, 18'h00123);
    endtask

    task automatic t_bank();
        dwrite(16'h7FF0, 8'hFD);
        dprobe(16'h7FF0, 1'b0);
        chk("R2 bank readback", data_rdata, 8'h05);
        chk("R11 rdata on read", data_rdata, 8'h05);
        dstop();
        cprobe(16'h9234);
        chk("R1 code banked", code_rom_addr, 18'h29234);
        dprobe(16'hC001, 1'b0);
        chk("R5 data rom sel", dsel(), 5'b10000);
        chk("R5 data rom addr", data_rom_addr, 18'h2C001);
        dprobe(16'hC001, 1'b1);
        chk("R5 rom write ignored", data_wr_en, 1'b0);
        chk("R11 rdata zero", data_rdata, 8'h00);
        dstop();
    endtask

    task automatic t_regions();
        dprobe(16'h7E10, 1'b1);
        chk("R6 gram sel", dsel(), 5'b01000);
        chk("R6 gram write", data_wr_en, 1'b1);
        dprobe(16'h7D20, 1'b1);
        chk("R8 scratch rw sel", dsel(), 5'b00100);
        chk("R8 scratch write", data_wr_en, 1'b1);
        dprobe(16'h1234, 1'b0);
        chk("R9 low xram", dsel(), 5'b00001);
        dprobe(16'h7CFF, 1'b0);
        chk("R9 7CFF xram", dsel(), 5'b00001);
        dprobe(16'h7F00, 1'b0);
        chk("R9 reg page", dsel(), 5'b00010);
        chk("R10 single select", $countones(dsel()), 1);
        dstop();
    endtask

    task automatic t_remap();
        dwrite(16'h7FF4, 8'hFF);
        dprobe(16'h7FF4, 1'b0);
        chk("R7 cfg readback", data_rdata, 8'h08);
        dstop();
        cprobe(16'h0040);
        chk("R4 scratch code", {code_sel_rom, code_sel_scr}, 2'b01);
        cprobe(16'h80FF);
        chk("R4 scratch alias", {code_sel_rom, code_sel_scr}, 2'b01);
        cprobe(16'h0100);
        chk("R4 above scratch", {code_sel_rom, code_sel_scr}, 2'b10);
        dprobe(16'h7D20, 1'b1);
        chk("R8 remapped sel", dsel(), 5'b00001);
        chk("R8 remapped write blocked", data_wr_en, 1'b0);
        dstop();
        @(negedge clk);
        boot_int_en = 1'b0;
        cprobe(16'h0040);
        chk("R3 ext only sel", {code_sel_rom, code_sel_scr}, 2'b10);
        chk("R3 ext only addr", code_rom_addr, 18'h28040);
        boot_int_en = 1'b1;
        dwrite(16'h7FF4, 8'hF7);
        dprobe(16'h7D20, 1'b0);
        chk("R8 scratch back", dsel(), 5'b00100);
        dstop();
        code_req = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_code_alias();
        t_bank();
        t_regions();
        t_remap();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule